// File: doc/BRIEF.md
# Software-Filled Fully-Associative Address Translation Cache

This block translates 32-bit virtual addresses into physical addresses through a small, fully-associative table of recent translations. A lookup presents a virtual address. The upper 20 bits are the virtual page number and the low 12 bits are the untranslated offset within a 4 KB page. Every valid entry compares its page number against the request in parallel. One clock edge later the block returns a registered result: either the physical address and a hit flag, or a one-cycle miss-exception pulse.

The hardware never fills the table on its own. A privileged software handler reacts to a miss exception and installs the missing translation through a dedicated write port. The write carries the entry index, which the handler chooses, together with the virtual and physical page numbers. The same port can also invalidate a single entry, and a flush input empties the whole table in one cycle.

Top module: `xlat_cache`

## Requirements
- R1: After reset, and after a reset applied later in operation, every entry is invalid, so any lookup reports a miss.
- R2: A lookup request whose page number matches a valid entry gives lk_hit=1 and lk_miss=0 one cycle later. lk_paddr is then that entry's physical page number in bits 31:12 and the request's bits 11:0 unchanged.
- R3: A lookup request that matches no valid entry gives lk_miss=1, lk_hit=0 and lk_paddr=0 one cycle later.
- R4: In a cycle with lk_req low, both lk_hit and lk_miss are 0 in the following cycle.
- R5: A write with wr_en=1 and wr_kill=0 stores the page pair at entry wr_idx and marks it valid. Overwriting an index removes the translation that entry held before.
- R6: A write with wr_en=1 and wr_kill=1 invalidates only entry wr_idx. All other entries keep their translations.
- R7: A flush clears every entry in one cycle. When a flush and a write occur in the same cycle, the flush wins and nothing is installed.
- R8: A lookup that happens in the same cycle as a write to the entry it would use sees that entry's contents from before the write.
- R9: When two valid entries hold the same virtual page number, the entry with the lower index supplies the translation.
- R10: lk_hit and lk_miss are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request strobe |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Registered: previous request matched an entry |
| lk_miss | output | 1 | Registered: miss-exception pulse for the previous request |
| lk_paddr | output | 32 | Registered physical address; 0 on a miss or with no request |
| wr_en | input | 1 | Software write command strobe |
| wr_kill | input | 1 | With wr_en: invalidate the entry instead of filling it |
| wr_idx | input | 4 | Entry index chosen by software |
| wr_vpn | input | 20 | Virtual page number to install |
| wr_ppn | input | 20 | Physical page number to install |
| flush | input | 1 | Invalidate all entries |

## Verification
The bench targets the moments where the table changes. A lookup in the same cycle as a write to its own entry must return the old page number; a design that forwards the write data returns the new one. An overwrite must make the old page number miss; a design that left the old tag matching would keep hitting. Two further cases check precedence: duplicate page numbers must resolve to the lower index, where a wrong priority order returns the wrong physical page, and a flush paired with a write must leave the table empty, where reversed precedence leaves one live entry. Offset pass-through uses all-ones offsets and page numbers so that a swapped or truncated field shows up in the returned address. A miss handler model fills at a software-chosen index and retries the lookup.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // Decoded table command, one per cycle.
  typedef enum logic [1:0] {
    TCMD_IDLE  = 2'd0,
    TCMD_FILL  = 2'd1,
    TCMD_KILL  = 2'd2,
    TCMD_CLEAR = 2'd3
  } tcmd_e;
endpackage

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  tcmd_e                           cmd,
  input  logic [IDX_W-1:0]                idx,
  input  logic [VPN_W-1:0]                vpn_in,
  input  logic [PPN_W-1:0]                ppn_in,
  output logic [ENTRIES-1:0]              vld_q,
  output logic [ENTRIES-1:0][VPN_W-1:0]   vpn_q,
  output logic [ENTRIES-1:0][PPN_W-1:0]   ppn_q
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic sel;
    assign sel = (idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[e] <= 1'b0;
      end else begin
        unique case (cmd)
          TCMD_CLEAR: vld_q[e] <= 1'b0;
          TCMD_KILL:  if (sel) vld_q[e] <= 1'b0;
          TCMD_FILL:  if (sel) vld_q[e] <= 1'b1;
          default: ;
        endcase
      end
    end

    // Tag and data carry no reset; the valid bit guards them.
    always_ff @(posedge clk) begin
      if (cmd == TCMD_FILL && sel) begin
        vpn_q[e] <= vpn_in;
        ppn_q[e] <= ppn_in;
      end
    end
  end

  // R7
  flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == TCMD_CLEAR) |=> (vld_q == '0));

  // R5
  fill_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == TCMD_FILL) |=> (vld_q[$past(idx)] && vpn_q[$past(idx)] == $past(vpn_in)));

  // R6
  kill_only_target_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == TCMD_KILL) |=> (!vld_q[$past(idx)] &&
      ((vld_q | ({{(ENTRIES-1){1'b0}}, 1'b1} << $past(idx))) ==
       ($past(vld_q) | ({{(ENTRIES-1){1'b0}}, 1'b1} << $past(idx))))));

endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic [ENTRIES-1:0]              vld,
  input  logic [ENTRIES-1:0][VPN_W-1:0]   vpn_tab,
  input  logic [ENTRIES-1:0][PPN_W-1:0]   ppn_tab,
  input  logic [VPN_W-1:0]                probe_vpn,
  output logic                            found,
  output logic [PPN_W-1:0]                found_ppn
);

  logic [ENTRIES-1:0] line;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign line[e] = vld[e] && (vpn_tab[e] == probe_vpn);
  end

  // Scan from the top so the lowest matching index is written last.
  always_comb begin
    found_ppn = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (line[e]) found_ppn = ppn_tab[e];
    end
  end

  assign found = |line;

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PPN_W  = PA_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_req,
  input  logic [VA_W-1:0]   lk_vaddr,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [PA_W-1:0]   lk_paddr,
  input  logic              wr_en,
  input  logic              wr_kill,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic              flush
);

  tcmd_e cmd;
  always_comb begin
    if (flush)                cmd = TCMD_CLEAR;
    else if (wr_en && wr_kill) cmd = TCMD_KILL;
    else if (wr_en)           cmd = TCMD_FILL;
    else                      cmd = TCMD_IDLE;
  end

  logic [ENTRIES-1:0]            vld_q;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;

  xlat_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .cmd    (cmd),
    .idx    (wr_idx),
    .vpn_in (wr_vpn),
    .ppn_in (wr_ppn),
    .vld_q  (vld_q),
    .vpn_q  (vpn_q),
    .ppn_q  (ppn_q)
  );

  logic             found;
  logic [PPN_W-1:0] found_ppn;

  xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_match (
    .vld       (vld_q),
    .vpn_tab   (vpn_q),
    .ppn_tab   (ppn_q),
    .probe_vpn (lk_vaddr[VA_W-1:OFF_W]),
    .found     (found),
    .found_ppn (found_ppn)
  );

  // Result register: compares against table state before this edge's write.
  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit   <= 1'b0;
      lk_miss  <= 1'b0;
      lk_paddr <= '0;
    end else begin
      lk_hit   <= lk_req && found;
      lk_miss  <= lk_req && !found;
      lk_paddr <= (lk_req && found) ? {found_ppn, lk_vaddr[OFF_W-1:0]} : '0;
    end
  end

  // R10
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(lk_hit && lk_miss));

  // R2
  req_answered_chk: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> (lk_hit || lk_miss));

  // R4
  idle_silent_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> (!lk_hit && !lk_miss));

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> (!lk_hit || lk_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

  // R3
  miss_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
    lk_miss |-> (lk_paddr == '0));

endmodule

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_req = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit, lk_miss;
  logic [31:0] lk_paddr;
  logic        wr_en = 1'b0, wr_kill = 1'b0, flush = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [19:0] wr_vpn = '0, wr_ppn = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xlat_cache u_xlat_cache (
    .clk(clk), .rst(rst), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
    .wr_en(wr_en), .wr_kill(wr_kill), .wr_idx(wr_idx),
    .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .flush(flush)
  );

  // op: 0 lookup, 1 fill, 2 kill, 3 flush
  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  idx;
    logic [19:0] vpn;
    logic [19:0] ppn;
    logic [11:0] off;
    logic        hit;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd0,  20'h12345, 20'h00000, 12'h678, 1'b0, 4'd1},  // R1 empty after reset
    '{2'd1, 4'd3,  20'h12345, 20'hABCDE, 12'h000, 1'b0, 4'd5},
    '{2'd0, 4'd0,  20'h12345, 20'hABCDE, 12'h678, 1'b1, 4'd2},  // R2
    '{2'd1, 4'd15, 20'hFFFFF, 20'h00001, 12'h000, 1'b0, 4'd5},
    '{2'd0, 4'd0,  20'hFFFFF, 20'h00001, 12'hFFF, 1'b1, 4'd2},  // R2 all-ones offset
    '{2'd0, 4'd0,  20'h00000, 20'h00000, 12'h000, 1'b0, 4'd3},  // R3
    '{2'd1, 4'd3,  20'h22222, 20'h33333, 12'h000, 1'b0, 4'd5},
    '{2'd0, 4'd0,  20'h12345, 20'h00000, 12'h111, 1'b0, 4'd5},  // R5 old gone
    '{2'd0, 4'd0,  20'h22222, 20'h33333, 12'h001, 1'b1, 4'd5},  // R5 new present
    '{2'd2, 4'd3,  20'h00000, 20'h00000, 12'h000, 1'b0, 4'd6},
    '{2'd0, 4'd0,  20'h22222, 20'h00000, 12'h001, 1'b0, 4'd6},  // R6 killed
    '{2'd0, 4'd0,  20'hFFFFF, 20'h00001, 12'h800, 1'b1, 4'd6},  // R6 neighbour kept
    '{2'd3, 4'd0,  20'h00000, 20'h00000, 12'h000, 1'b0, 4'd7},
    '{2'd0, 4'd0,  20'hFFFFF, 20'h00000, 12'h800, 1'b0, 4'd7}   // R7 flushed
  };

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // Checks one lookup result sampled at the falling edge after the response edge.
  task automatic chk_resp(input string rq, input logic exp_hit, input logic [31:0] exp_pa);
    chk(rq, "hit",   {31'd0, lk_hit},  {31'd0, exp_hit});
    chk(rq, "miss",  {31'd0, lk_miss}, {31'd0, !exp_hit});
    chk(rq, "paddr", lk_paddr, exp_hit ? exp_pa : 32'd0);
    chk("R10", "excl", {31'd0, lk_hit && lk_miss}, 32'd0);
  endtask

  task automatic lookup(input logic [31:0] va);
    lk_req = 1'b1; lk_vaddr = va;
    @(posedge clk); @(negedge clk);
    lk_req = 1'b0;
  endtask

  task automatic twrite(input logic kill, input logic [3:0] i,
                        input logic [19:0] v, input logic [19:0] p);
    wr_en = 1'b1; wr_kill = kill; wr_idx = i; wr_vpn = v; wr_ppn = p;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_kill = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(posedge clk); @(negedge clk);
    flush = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state of outputs
    chk("R1", "hit at reset", {31'd0, lk_hit}, 32'd0);
    chk("R1", "paddr at reset", lk_paddr, 32'd0);

    for (int k = 0; k < NV; k++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[k].rq, k);
      case (VECS[k].op)
        2'd0: begin
          lookup({VECS[k].vpn, VECS[k].off});
          chk_resp(tag, VECS[k].hit, {VECS[k].ppn, VECS[k].off});
        end
        2'd1: twrite(1'b0, VECS[k].idx, VECS[k].vpn, VECS[k].ppn);
        2'd2: twrite(1'b1, VECS[k].idx, VECS[k].vpn, VECS[k].ppn);
        default: do_flush();
      endcase
    end

    // R4: idle cycle after a hitting lookup gives no response
    twrite(1'b0, 4'd0, 20'h0AAAA, 20'h0BBBB);
    lookup(32'h0AAAA123);
    @(negedge clk);
    chk("R4", "hit idle", {31'd0, lk_hit}, 32'd0);
    chk("R4", "miss idle", {31'd0, lk_miss}, 32'd0);

    // R8: lookup and overwrite of its entry in the same cycle
    lk_req = 1'b1; lk_vaddr = 32'h0AAAA456;
    wr_en = 1'b1; wr_idx = 4'd0; wr_vpn = 20'h0AAAA; wr_ppn = 20'h0CCCC;
    @(posedge clk); @(negedge clk);
    lk_req = 1'b0; wr_en = 1'b0;
    chk_resp("R8 old contents", 1'b1, 32'h0BBBB456);
    lookup(32'h0AAAA456);
    chk_resp("R8 new afterwards", 1'b1, 32'h0CCCC456);
    // R8: installing a missing page in the same cycle still misses
    lk_req = 1'b1; lk_vaddr = 32'h05555000;
    wr_en = 1'b1; wr_idx = 4'd7; wr_vpn = 20'h05555; wr_ppn = 20'h06666;
    @(posedge clk); @(negedge clk);
    lk_req = 1'b0; wr_en = 1'b0;
    chk_resp("R8 fill same cycle", 1'b0, 32'd0);

    // R9: duplicate page numbers, lower index wins
    twrite(1'b0, 4'd12, 20'h0D00D, 20'h11111);
    twrite(1'b0, 4'd4,  20'h0D00D, 20'h22222);
    lookup(32'h0D00D00F);
    chk_resp("R9 lowest index", 1'b1, 32'h2222200F);
    twrite(1'b1, 4'd4, 20'h0, 20'h0);
    lookup(32'h0D00D00F);
    chk_resp("R9 next index", 1'b1, 32'h1111100F);

    // R7: flush beats a write in the same cycle
    flush = 1'b1; wr_en = 1'b1; wr_idx = 4'd9; wr_vpn = 20'h07777; wr_ppn = 20'h08888;
    @(posedge clk); @(negedge clk);
    flush = 1'b0; wr_en = 1'b0;
    lookup(32'h07777000);
    chk_resp("R7 flush wins", 1'b0, 32'd0);
    lookup(32'h0D00D000);
    chk_resp("R7 all cleared", 1'b0, 32'd0);

    // R5: miss handler model fills a software-chosen slot and retries
    for (int t = 0; t < 4; t++) begin
      logic [19:0] v;
      v = 20'h40000 + 20'(t * 3);
      lookup({v, 12'h0C4});
      chk_resp("R5 handler first miss", 1'b0, 32'd0);
      if (lk_miss) twrite(1'b0, 4'(15 - t * 2), v, v ^ 20'hFFFFF);
      lookup({v, 12'h0C4});
      chk_resp("R5 handler retry", 1'b1, {v ^ 20'hFFFFF, 12'h0C4});
    end

    // R1: reset later in operation empties the table
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    lookup(32'h400000C4);
    chk_resp("R1 reset mid-run", 1'b0, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule